// File: doc/BRIEF.md
# Sub-word configuration access adapter

This block lets a requester issue configuration reads and writes of 8, 16 or 32 bits to a back end that can only run aligned 32-bit configuration cycles. The back end is reached through two registers: an address register and a data register that sits 4 bytes above it. Every accepted access first writes a configuration address word into the address register. The data register is then read or written.

A request is checked against the bus-number and device/function limits when it is accepted. A request outside those limits gets a not-found status and causes no back-end cycle. For byte and halfword reads, the block takes the addressed lane from the fetched dword, using big-endian lane numbering, and zero-extends it. Byte and halfword writes become a read-modify-write: the block fetches the dword, merges the new lane into it, and writes the whole dword back. When the back end reports a timeout on a read, the fetched dword is replaced with all ones.

Top module: `cfg_subword_adapter`

## Requirements
- R1: The address word written to the address register carries the bus number in bits 23:16, the device/function number in bits 15:8 and offset bits 7:2 in bits 7:2. Bit 1 is 0 and bits 31:24 are 0.
- R2: Bit 0 of the address word is 1 when the bus number is nonzero (a Type 1 access) and 0 for bus 0 (a Type 0 access).
- R3: A request with bus number above 7 or device/function number above 127 completes with `rsp_notfound`=1 and issues no back-end cycle. The returned read data is all ones at the requested width: 0x000000FF for a byte, 0x0000FFFF for a halfword, 0xFFFFFFFF for a word. A refused write changes no back-end data.
- R4: Each accepted access first writes the address register at offset 0x500. Only after that write is acknowledged does the block access the data register at offset 0x504.
- R5: `req_size` is encoded as 0 for a byte, 1 for a halfword, and 2 or 3 for a word. A byte read returns big-endian lane (offset XOR 3) & 3, where lane 0 is dword bits 31:24. This equals dword bits [8*offset[1:0] +: 8], zero-extended.
- R6: A halfword read returns big-endian half ((offset XOR 2) >> 1) & 1, where half 0 is bits 31:16. This equals dword bits [16*offset[1] +: 16], zero-extended.
- R7: A byte or halfword write runs four back-end cycles in this order: address write, data read, address write, data write. The data written is the dword just read, with only the selected lane replaced by the low bits of `req_wdata`.
- R8: If the back end acknowledges a data read with `be_timeout`=1, the dword is taken as all ones before lane extraction.
- R9: A word access ignores offset bits 1:0. A word write runs exactly two back-end cycles: address write, then data write.
- R10: `req_ready` is high only when no access is in progress. `rsp_done` is a single-cycle pulse, after which `req_ready` is high again.
- R11: While `be_valid` is high and not yet acknowledged, `be_write`, `be_addr` and `be_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device/function number |
| req_offset | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_done | output | 1 | Completion pulse |
| rsp_notfound | output | 1 | Request refused by range check |
| rsp_rdata | output | 32 | Read result, zero-extended |
| be_valid | output | 1 | Back-end cycle request |
| be_write | output | 1 | Back-end cycle is a write |
| be_addr | output | 12 | Register offset: address or data register |
| be_wdata | output | 32 | Back-end write data |
| be_ack | input | 1 | Back-end cycle complete (one cycle) |
| be_rdata | input | 32 | Back-end read data, valid with ack |
| be_timeout | input | 1 | Target did not respond, valid with ack |

## Verification
Two functions meet on one acknowledge cycle. In a sub-word write, the acknowledge of the data read must feed lane merging and also move the sequencer back to a second address write. The bench provokes this with byte and halfword writes whose upper `req_wdata` bits are deliberately nonzero. It then checks the fourth logged back-end write and reads the dword back, which shows whether the right lane was replaced while the other lanes and the second address word were kept. Range refusal and response completion also share a cycle. The bench sends out-of-range reads and writes and checks that no back-end cycle is logged while the width-sized all-ones data is returned.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int CFG_DW = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } cfg_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_DONE
  } seq_state_e;

  // all ones at the width a request asks for
  function automatic logic [CFG_DW-1:0] size_ones(input logic [1:0] sz);
    logic [CFG_DW-1:0] m;
    case (sz)
      2'd0:    m = CFG_DW'(8'hFF);
      2'd1:    m = CFG_DW'(16'hFFFF);
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cfgw_addr_gen.sv
module cfgw_addr_gen #(
  parameter int DW        = 32,
  parameter int BW        = 8,
  parameter int FW        = 8,
  parameter int OW        = 8,
  parameter int BUS_MAX   = 7,
  parameter int DEVFN_MAX = 127
) (
  input  logic [BW-1:0] bus,
  input  logic [FW-1:0] devfn,
  input  logic [OW-1:0] offset,
  output logic          in_range,
  output logic [DW-1:0] addr_word
);
  localparam int PADW = DW - BW - FW - OW;

  logic type1;

  always_comb begin
    in_range  = (int'(bus) <= BUS_MAX) && (int'(devfn) <= DEVFN_MAX);
    type1     = (bus != '0);
    addr_word = {{PADW{1'b0}}, bus, devfn, offset[OW-1:2], 1'b0, type1};
  end
endmodule

// File: rtl/cfgw_lane_unit.sv
module cfgw_lane_unit #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] dword,
  input  logic [DW-1:0] wval,
  input  logic [1:0]    size,
  input  logic [1:0]    off,
  output logic [DW-1:0] rd_ext,
  output logic [DW-1:0] merged
);
  localparam int NB = DW / 8;

  // read side: shift the addressed lane down, then cut to width
  always_comb begin
    case (size)
      2'd0:    rd_ext = (dword >> (8 * off))       & DW'(8'hFF);
      2'd1:    rd_ext = (dword >> (16 * off[1]))   & DW'(16'hFFFF);
      default: rd_ext = dword;
    endcase
  end

  // write side: per byte lane, keep the fetched byte or take the new one
  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic       sel;
    logic [7:0] src;
    always_comb begin
      case (size)
        2'd0: begin
          sel = (off == 2'(i));
          src = wval[7:0];
        end
        2'd1: begin
          sel = (off[1] == 1'((i >> 1) & 1));
          src = wval[8*(i%2) +: 8];
        end
        default: begin
          sel = 1'b1;
          src = wval[8*i +: 8];
        end
      endcase
    end
    assign merged[8*i +: 8] = sel ? src : dword[8*i +: 8];
  end
endmodule

// File: rtl/cfgw_seq.sv
module cfgw_seq
  import cfgw_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          RW       = 12,
  parameter logic [11:0] ADDR_OFS = 12'h500,
  parameter int          STEP     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [1:0]    req_off_lo,
  input  logic [DW-1:0] req_wdata,
  input  logic          in_range,
  input  logic [DW-1:0] addr_word,
  output logic          rsp_done,
  output logic          rsp_notfound,
  output logic [DW-1:0] rsp_rdata,
  output logic          be_valid,
  output logic          be_write,
  output logic [RW-1:0] be_addr,
  output logic [DW-1:0] be_wdata,
  input  logic          be_ack,
  input  logic          be_rdata_ok,
  output logic [1:0]    size_q,
  output logic [1:0]    off_q,
  output logic [DW-1:0] wbuf_q,
  input  logic [DW-1:0] rd_ext,
  input  logic [DW-1:0] merged
);
  localparam logic [RW-1:0] A_REG = RW'(ADDR_OFS);
  localparam logic [RW-1:0] D_REG = RW'(ADDR_OFS + STEP);

  seq_state_e    state;
  logic          wr_q;
  logic          rmw_q;
  logic [DW-1:0] addr_q;
  logic          word_q;

  assign word_q = size_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      wr_q         <= 1'b0;
      rmw_q        <= 1'b0;
      size_q       <= '0;
      off_q        <= '0;
      addr_q       <= '0;
      wbuf_q       <= '0;
      rsp_rdata    <= '0;
      rsp_notfound <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q      <= req_write;
            size_q    <= req_size;
            off_q     <= req_off_lo;
            addr_q    <= addr_word;
            wbuf_q    <= req_wdata;
            rmw_q     <= 1'b0;
            rsp_rdata <= '0;
            if (!in_range) begin
              rsp_notfound <= 1'b1;
              if (!req_write) rsp_rdata <= size_ones(req_size);
              state <= ST_DONE;
            end else begin
              rsp_notfound <= 1'b0;
              state        <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          if (be_ack) state <= (wr_q && (rmw_q || word_q)) ? ST_WR : ST_RD;
        end
        ST_RD: begin
          if (be_ack) begin
            if (wr_q) begin
              wbuf_q <= merged;
              rmw_q  <= 1'b1;
              state  <= ST_ADDR;
            end else begin
              rsp_rdata <= rd_ext;
              state     <= ST_DONE;
            end
          end
        end
        ST_WR: begin
          if (be_ack) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    rsp_done  = (state == ST_DONE);
    be_valid  = (state == ST_ADDR) || (state == ST_RD) || (state == ST_WR);
    be_write  = (state != ST_RD);
    be_addr   = (state == ST_ADDR) ? A_REG : D_REG;
    be_wdata  = (state == ST_ADDR) ? addr_q : wbuf_q;
  end

  logic unused_ok;
  assign unused_ok = be_rdata_ok;
endmodule

// File: rtl/cfg_subword_adapter.sv
module cfg_subword_adapter
  import cfgw_pkg::*;
#(
  parameter int          DW        = CFG_DW,
  parameter int          RW        = 12,
  parameter int          BW        = 8,
  parameter int          FW        = 8,
  parameter int          OW        = 8,
  parameter int          BUS_MAX   = 7,
  parameter int          DEVFN_MAX = 127,
  parameter logic [11:0] ADDR_OFS  = 12'h500,
  parameter int          STEP      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [BW-1:0] req_bus,
  input  logic [FW-1:0] req_devfn,
  input  logic [OW-1:0] req_offset,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic          rsp_notfound,
  output logic [DW-1:0] rsp_rdata,
  output logic          be_valid,
  output logic          be_write,
  output logic [RW-1:0] be_addr,
  output logic [DW-1:0] be_wdata,
  input  logic          be_ack,
  input  logic [DW-1:0] be_rdata,
  input  logic          be_timeout
);
  logic          in_range;
  logic [DW-1:0] addr_word;
  logic [1:0]    size_q;
  logic [1:0]    off_q;
  logic [DW-1:0] wbuf_q;
  logic [DW-1:0] fetched;
  logic [DW-1:0] rd_ext;
  logic [DW-1:0] merged;

  // a silent target reads back as all ones
  assign fetched = be_timeout ? '1 : be_rdata;

  cfgw_addr_gen #(
    .DW(DW), .BW(BW), .FW(FW), .OW(OW),
    .BUS_MAX(BUS_MAX), .DEVFN_MAX(DEVFN_MAX)
  ) u_addr (
    .bus      (req_bus),
    .devfn    (req_devfn),
    .offset   (req_offset),
    .in_range (in_range),
    .addr_word(addr_word)
  );

  cfgw_lane_unit #(.DW(DW)) u_lane (
    .dword (fetched),
    .wval  (wbuf_q),
    .size  (size_q),
    .off   (off_q),
    .rd_ext(rd_ext),
    .merged(merged)
  );

  cfgw_seq #(
    .DW(DW), .RW(RW), .ADDR_OFS(ADDR_OFS), .STEP(STEP)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_off_lo  (req_offset[1:0]),
    .req_wdata   (req_wdata),
    .in_range    (in_range),
    .addr_word   (addr_word),
    .rsp_done    (rsp_done),
    .rsp_notfound(rsp_notfound),
    .rsp_rdata   (rsp_rdata),
    .be_valid    (be_valid),
    .be_write    (be_write),
    .be_addr     (be_addr),
    .be_wdata    (be_wdata),
    .be_ack      (be_ack),
    .be_rdata_ok (be_timeout),
    .size_q      (size_q),
    .off_q       (off_q),
    .wbuf_q      (wbuf_q),
    .rd_ext      (rd_ext),
    .merged      (merged)
  );
endmodule

// File: rtl/cfgw_chk.sv
module cfgw_chk #(
  parameter int          DW        = 32,
  parameter int          RW        = 12,
  parameter int          BUS_MAX   = 7,
  parameter int          DEVFN_MAX = 127,
  parameter logic [11:0] ADDR_OFS  = 12'h500,
  parameter int          STEP      = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [7:0]    req_bus,
  input logic [7:0]    req_devfn,
  input logic          rsp_done,
  input logic          rsp_notfound,
  input logic          be_valid,
  input logic          be_write,
  input logic [RW-1:0] be_addr,
  input logic [DW-1:0] be_wdata,
  input logic          be_ack
);
  localparam logic [RW-1:0] A_REG = RW'(ADDR_OFS);
  localparam logic [RW-1:0] D_REG = RW'(ADDR_OFS + STEP);

  logic bad_req;
  assign bad_req = (int'(req_bus) > BUS_MAX) || (int'(req_devfn) > DEVFN_MAX);

  // R3
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && bad_req |=> !be_valid && rsp_done && rsp_notfound);

  // R4
  addr_first_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !bad_req |=> be_valid && be_write && be_addr == A_REG);

  // R4
  data_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
    be_valid && be_ack && be_addr == A_REG |=> be_valid && be_addr == D_REG);

  // R1
  addr_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    be_valid && be_addr == A_REG |-> be_write && be_wdata[1] == 1'b0 && be_wdata[31:24] == 8'h00);

  // R2
  type_bit_chk: assert property (@(posedge clk) disable iff (rst)
    be_valid && be_addr == A_REG |-> be_wdata[0] == (be_wdata[23:16] != 8'h00));

  // R11
  be_hold_chk: assert property (@(posedge clk) disable iff (rst)
    be_valid && !be_ack |=> be_valid && $stable(be_addr) && $stable(be_write) && $stable(be_wdata));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done && req_ready);

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    be_valid |-> !req_ready && !rsp_done);
endmodule

bind cfg_subword_adapter cfgw_chk #(
  .DW(DW), .RW(RW), .BUS_MAX(BUS_MAX), .DEVFN_MAX(DEVFN_MAX),
  .ADDR_OFS(ADDR_OFS), .STEP(STEP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_bus     (req_bus),
  .req_devfn   (req_devfn),
  .rsp_done    (rsp_done),
  .rsp_notfound(rsp_notfound),
  .be_valid    (be_valid),
  .be_write    (be_write),
  .be_addr     (be_addr),
  .be_wdata    (be_wdata),
  .be_ack      (be_ack)
);

// File: tb/tb_cfg_subword_adapter.sv
`timescale 1ns/1ps
module tb_cfg_subword_adapter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [7:0]  req_bus = 8'd0;
  logic [7:0]  req_devfn = 8'd0;
  logic [7:0]  req_offset = 8'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_done;
  logic        rsp_notfound;
  logic [31:0] rsp_rdata;
  logic        be_valid;
  logic        be_write;
  logic [11:0] be_addr;
  logic [31:0] be_wdata;
  logic        be_ack = 1'b0;
  logic [31:0] be_rdata = 32'd0;
  logic        be_timeout = 1'b0;

  always #2.5 clk = ~clk;

  cfg_subword_adapter dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_bus(req_bus), .req_devfn(req_devfn),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_notfound(rsp_notfound), .rsp_rdata(rsp_rdata),
    .be_valid(be_valid), .be_write(be_write), .be_addr(be_addr),
    .be_wdata(be_wdata), .be_ack(be_ack), .be_rdata(be_rdata),
    .be_timeout(be_timeout)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // back-end model: 64-dword register file, ack after 3 cycles, transaction log
  logic [31:0] mem [64];
  logic [31:0] cur_addr = 32'd0;
  logic [1:0]  lat = 2'd0;
  bit          to_mode = 1'b0;
  logic [7:0]  log_n = 8'd0;
  logic        log_w [256];
  logic [11:0] log_a [256];
  logic [31:0] log_d [256];

  initial for (int i = 0; i < 64; i++) mem[i] = 32'h11223344;

  always @(posedge clk) begin
    if (rst) begin
      be_ack <= 1'b0;
      lat    <= 2'd0;
    end else if (be_ack) begin
      be_ack     <= 1'b0;
      be_timeout <= 1'b0;
    end else if (be_valid) begin
      if (lat == 2'd2) begin
        lat           <= 2'd0;
        be_ack        <= 1'b1;
        log_w[log_n]  <= be_write;
        log_a[log_n]  <= be_addr;
        log_d[log_n]  <= be_write ? be_wdata : 32'd0;
        log_n         <= log_n + 8'd1;
        if (be_write) begin
          if (be_addr == 12'h500) cur_addr <= be_wdata;
          else                    mem[cur_addr[7:2]] <= be_wdata;
        end else begin
          be_rdata   <= to_mode ? 32'h5A5A0F0F : mem[cur_addr[7:2]];
          be_timeout <= to_mode;
        end
      end else begin
        lat <= lat + 2'd1;
      end
    end
  end

  // vector: {wr, size, bus, devfn, off, wdata, exp_rdata, exp_nf, exp_ntx}
  localparam int NV = 19;
  localparam logic [94:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'd0, 8'h08, 8'h00, 32'h0,        32'h00000044, 1'b0, 3'd2}, // R5
    {1'b0, 2'd0, 8'd0, 8'h08, 8'h01, 32'h0,        32'h00000033, 1'b0, 3'd2}, // R5
    {1'b0, 2'd0, 8'd0, 8'h08, 8'h02, 32'h0,        32'h00000022, 1'b0, 3'd2}, // R5
    {1'b0, 2'd0, 8'd0, 8'h10, 8'h07, 32'h0,        32'h00000011, 1'b0, 3'd2}, // R5
    {1'b0, 2'd1, 8'd0, 8'h08, 8'h04, 32'h0,        32'h00003344, 1'b0, 3'd2}, // R6
    {1'b0, 2'd1, 8'd0, 8'h08, 8'h06, 32'h0,        32'h00001122, 1'b0, 3'd2}, // R6
    {1'b0, 2'd2, 8'd0, 8'h08, 8'h08, 32'h0,        32'h11223344, 1'b0, 3'd2}, // R9
    {1'b0, 2'd2, 8'd0, 8'h08, 8'h0B, 32'h0,        32'h11223344, 1'b0, 3'd2}, // R9
    {1'b0, 2'd0, 8'd8, 8'h08, 8'h00, 32'h0,        32'h000000FF, 1'b1, 3'd0}, // R3
    {1'b0, 2'd1, 8'd0, 8'h80, 8'h00, 32'h0,        32'h0000FFFF, 1'b1, 3'd0}, // R3
    {1'b0, 2'd2, 8'd9, 8'h00, 8'h00, 32'h0,        32'hFFFFFFFF, 1'b1, 3'd0}, // R3
    {1'b1, 2'd0, 8'd0, 8'h08, 8'h11, 32'hFFFFFFAB, 32'h00000000, 1'b0, 3'd4}, // R7
    {1'b0, 2'd2, 8'd0, 8'h08, 8'h10, 32'h0,        32'h1122AB44, 1'b0, 3'd2}, // R7
    {1'b1, 2'd1, 8'd0, 8'h08, 8'h16, 32'h9876CDEF, 32'h00000000, 1'b0, 3'd4}, // R7
    {1'b0, 2'd2, 8'd0, 8'h08, 8'h14, 32'h0,        32'hCDEF3344, 1'b0, 3'd2}, // R7
    {1'b1, 2'd2, 8'd0, 8'h08, 8'h1B, 32'hDEADBEEF, 32'h00000000, 1'b0, 3'd2}, // R9
    {1'b0, 2'd0, 8'd0, 8'h08, 8'h18, 32'h0,        32'h000000EF, 1'b0, 3'd2}, // R9
    {1'b1, 2'd2, 8'd8, 8'h08, 8'h18, 32'h01020304, 32'h00000000, 1'b1, 3'd0}, // R3
    {1'b0, 2'd2, 8'd3, 8'h10, 8'h18, 32'h0,        32'hDEADBEEF, 1'b0, 3'd2}  // R2
  };

  logic [31:0] got_rdata;
  logic        got_nf;
  logic [7:0]  base;

  task automatic access(input logic wr, input logic [1:0] sz, input logic [7:0] bus,
                        input logic [7:0] dev, input logic [7:0] off, input logic [31:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base       = log_n;
    req_valid  = 1'b1;
    req_write  = wr;
    req_size   = sz;
    req_bus    = bus;
    req_devfn  = dev;
    req_offset = off;
    req_wdata  = wd;
    @(negedge clk);
    req_valid = 1'b0;
    // R10: busy once accepted
    check(!req_ready, "R10 ready low while busy", 32'(req_ready), 32'd0);
    while (!rsp_done) @(negedge clk);
    got_rdata = rsp_rdata;
    got_nf    = rsp_notfound;
    @(negedge clk);
    // R10: done was a single pulse
    check(!rsp_done && req_ready, "R10 done pulse", 32'(rsp_done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check(req_ready && !rsp_done && !be_valid, "R10 reset state", {29'd0, req_ready, rsp_done, be_valid}, 32'h4);

    for (int v = 0; v < NV; v++) begin
      logic        wr;
      logic [1:0]  sz;
      logic [7:0]  bus, dev, off;
      logic [31:0] wd, exp_rd, exp_aw;
      logic        exp_nf;
      logic [2:0]  ntx;
      logic [7:0]  got_ntx;
      wr = VEC[v][94]; sz = VEC[v][93:92]; bus = VEC[v][91:84]; dev = VEC[v][83:76];
      off = VEC[v][75:68]; wd = VEC[v][67:36]; exp_rd = VEC[v][35:4];
      exp_nf = VEC[v][3]; ntx = VEC[v][2:0];
      access(wr, sz, bus, dev, off, wd);
      got_ntx = log_n - base;
      check(got_nf == exp_nf, $sformatf("R3 status vec %0d", v), 32'(got_nf), 32'(exp_nf));
      check(got_rdata == exp_rd, $sformatf("R5 R6 R9 rdata vec %0d", v), got_rdata, exp_rd);
      check(got_ntx == 8'(ntx), $sformatf("R3 R7 R9 cycle count vec %0d", v), 32'(got_ntx), 32'(ntx));
      if (ntx != 3'd0) begin
        exp_aw = {8'h00, bus, dev, off & 8'hFC} | 32'(bus != 8'd0);
        check(log_w[base] && log_a[base] == 12'h500, $sformatf("R4 first is address write vec %0d", v),
              32'(log_a[base]), 32'h500);
        check(log_d[base] == exp_aw, $sformatf("R1 R2 address word vec %0d", v), log_d[base], exp_aw);
        check(log_a[8'(base + 1)] == 12'h504 && log_w[8'(base + 1)] == (wr && ntx == 3'd2),
              $sformatf("R4 data access vec %0d", v), 32'(log_a[8'(base + 1)]), 32'h504);
      end
      if (ntx == 3'd4) begin
        check(log_w[8'(base + 2)] && log_a[8'(base + 2)] == 12'h500 && log_d[8'(base + 2)] == log_d[base],
              $sformatf("R7 second address write vec %0d", v), log_d[8'(base + 2)], log_d[base]);
        check(log_w[8'(base + 3)] && log_a[8'(base + 3)] == 12'h504,
              $sformatf("R7 final data write vec %0d", v), 32'(log_a[8'(base + 3)]), 32'h504);
      end
    end

    // R8: timeout replaces the fetched dword with all ones
    to_mode = 1'b1;
    access(1'b0, 2'd0, 8'd0, 8'h08, 8'h02, 32'd0);
    check(got_rdata == 32'h000000FF && !got_nf, "R8 timeout byte read", got_rdata, 32'h000000FF);
    access(1'b0, 2'd1, 8'd0, 8'h08, 8'h00, 32'd0);
    check(got_rdata == 32'h0000FFFF, "R8 timeout half read", got_rdata, 32'h0000FFFF);
    access(1'b0, 2'd3, 8'd1, 8'h08, 8'h00, 32'd0);
    check(got_rdata == 32'hFFFFFFFF, "R8 timeout word read", got_rdata, 32'hFFFFFFFF);
    to_mode = 1'b0;

    // R7: halfword write into the low half keeps the upper half
    access(1'b1, 2'd1, 8'd0, 8'h08, 8'h21, 32'hFFFF0102);
    check(log_d[8'(base + 3)] == 32'h11220102, "R7 merged low half", log_d[8'(base + 3)], 32'h11220102);
    // R5: byte write to lane at offset 3 lands in bits 31:24
    access(1'b1, 2'd0, 8'd0, 8'h08, 8'h27, 32'h000000C3);
    access(1'b0, 2'd2, 8'd0, 8'h08, 8'h24, 32'd0);
    check(got_rdata == 32'hC3223344, "R5 byte lane 3 write", got_rdata, 32'hC3223344);

    // R3: refused write left the target dword untouched
    check(mem[6] == 32'hDEADBEEF, "R3 refused write no effect", mem[6], 32'hDEADBEEF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule